// File: doc/BRIEF.md
# Boot Remap Address Decoder

This block steers every bus request to its memory target. A request carries a master number and an address. The decoder answers in the same cycle with three things: a one-hot target select, the offset inside that target, and an error flag. The possible targets are the boot ROM, external chip select 0, and three partitions (A, B, C) of a 160 KB on-chip SRAM. That SRAM is built from ten 16 KB banks.

What address zero reaches depends on two things. The first is a boot strap pin, sampled while reset is asserted. The second is a remap bit, which only the instruction-fetch master (master 0) and the data master (master 1) have, one bit each. Once a master's bit is set, address zero reaches partition C for that master alone.

Software sets the sizes of partitions A and B. Partition C keeps every remaining bank. A size write is rejected if it uses an unknown code or would leave C with fewer than two banks. A rejected write leaves the old sizes in place and sets a sticky error bit. The size and remap registers change on the clock edge that takes the write. The address decode itself is purely combinational.

Top module: `boot_remap_decoder`

## Requirements
- R1: After reset, A and B are empty and C holds all 160 KB. Offsets 0x00000..0x27FFF in the C window hit C. Offset 0x28000 and above in the C window is an error. Any access to the A or B window is an error.
- R2: The strap is captured only while `rst_n` is low. When it was 1, address window 0 goes to the boot ROM (`tgt_sel` bit 0). When it was 0, window 0 goes to chip select 0 (`tgt_sel` bit 1). Changing the pin after reset has no effect.
- R3: The address window is `req_addr[31:20]`. Window 1 is partition A (`tgt_sel` bit 2), window 2 is partition B (bit 3) and window 3 is partition C (bit 4). On a hit, `tgt_offset` equals `req_addr[19:0]` zero-extended to 32 bits.
- R4: The size codes are 0→0 KB, 1→16 KB, 2→32 KB and 3→64 KB. C gets 160 KB minus the sizes of A and B. An offset at or beyond a partition's current size gives `tgt_err`=1 with `tgt_sel`=0 and `tgt_offset`=0.
- R5: A write with a code of 4..7 for A or B, or one that leaves C under two banks, changes no size and sets `cfg_err`. `cfg_err` then stays 1 until reset, including across later legal writes.
- R6: `remap_set` bit 0 sets the remap bit of master 0 and bit 1 sets that of master 1. A remapped master reads window 0 as partition C, with offset `req_addr[19:0]` and the bound set by C's size. The other master is not affected.
- R7: Masters 2 and 3 never see the remap. For them window 0 always follows the strap.
- R8: A remap write with a 0 bit does not clear a set remap bit. Only reset clears the remap bits.
- R9: A size or remap write does not change the decode in its own cycle. It takes effect from the next cycle on.
- R10: Windows 4 and above are unmapped and give `tgt_err`=1 and `tgt_sel`=0. `tgt_sel` is never more than one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; strap is captured while low |
| boot_sel_pin | input | 1 | Boot strap: 1 selects boot ROM, 0 selects chip select 0 |
| cfg_we | input | 1 | Partition size write strobe |
| cfg_a_code | input | 3 | Size code for partition A |
| cfg_b_code | input | 3 | Size code for partition B |
| remap_we | input | 1 | Remap write strobe |
| remap_set | input | 2 | Per-master remap set bits (bit 0: master 0, bit 1: master 1) |
| req_master | input | 2 | Requesting master number |
| req_addr | input | 32 | Request address |
| tgt_sel | output | 5 | One-hot target: ROM, chip select 0, A, B, C |
| tgt_offset | output | 32 | Target-relative offset |
| tgt_err | output | 1 | Unmapped or out-of-size access |
| cfg_err | output | 1 | Sticky rejected-size-write flag |

## Verification
Two functions can fall in the same cycle. One is a register write, either a new partition size or a remap set. The other is a decode that depends on that register. The bench provokes this by issuing a size write together with an access just past the old size of A, and a remap set together with an access to address zero from the master being remapped. A behavioural model applies writes only at the clock edge, so the bench expects the old mapping in the write cycle and the new mapping in the following cycle.

// File: rtl/brd_pkg.sv
// Shared types and helpers for the boot remap decoder.
// Assumes a 3-bit partition size code where only values 0..3 are legal.
package brd_pkg;

    localparam int N_TGT     = 5;
    localparam int SZ_CODE_W = 3;

    // Bit position of each target in the one-hot select
    typedef enum logic [2:0] {
        TGT_ROM = 3'd0,
        TGT_CS0 = 3'd1,
        TGT_PA  = 3'd2,
        TGT_PB  = 3'd3,
        TGT_PC  = 3'd4
    } tgt_e;

    // True when a size code is one of the four defined values
    function automatic logic sz_code_ok(input logic [SZ_CODE_W-1:0] code);
        return code <= 3'd3;
    endfunction

    // Number of banks a legal size code stands for
    function automatic logic [SZ_CODE_W-1:0] sz_code_banks(input logic [SZ_CODE_W-1:0] code);
        logic [SZ_CODE_W-1:0] n;
        case (code)
            3'd1:    n = 3'd1;
            3'd2:    n = 3'd2;
            3'd3:    n = 3'd4;
            default: n = 3'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/brd_part_cfg.sv
// Partition size register for the banked on-chip SRAM.
// Holds the bank counts of partitions A and B and derives C from the rest.
// Rejects a write with an unknown code, or one that leaves C below MIN_C_BANKS,
// and records the rejection in a sticky flag. Assumes synchronous active-low reset.
module brd_part_cfg
    import brd_pkg::*;
#(
    parameter int N_BANKS     = 10,
    parameter int MIN_C_BANKS = 2,
    parameter int CNT_W       = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [SZ_CODE_W-1:0] cfg_a_code,
    input  logic [SZ_CODE_W-1:0] cfg_b_code,
    output logic [CNT_W-1:0]     a_banks,
    output logic [CNT_W-1:0]     b_banks,
    output logic [CNT_W-1:0]     c_banks,
    output logic                 cfg_err
);

    logic [CNT_W-1:0] a_q, b_q;
    logic [CNT_W-1:0] a_req, b_req;
    logic             req_ok;
    logic             err_q;

    // Translate the requested codes and judge whether the split is allowed
    always_comb begin
        a_req  = CNT_W'(sz_code_banks(cfg_a_code));
        b_req  = CNT_W'(sz_code_banks(cfg_b_code));
        req_ok = sz_code_ok(cfg_a_code) && sz_code_ok(cfg_b_code)
                 && ((int'(a_req) + int'(b_req) + MIN_C_BANKS) <= N_BANKS);
    end

    // Accept a legal write or keep the old split and flag the rejection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            err_q <= 1'b0;
        end else if (cfg_we) begin
            if (req_ok) begin
                a_q <= a_req;
                b_q <= b_req;
            end else begin
                err_q <= 1'b1;
            end
        end
    end

    // Partition C owns every bank not held by A or B
    always_comb begin
        c_banks = CNT_W'(N_BANKS) - a_q - b_q;
    end

    assign a_banks = a_q;
    assign b_banks = b_q;
    assign cfg_err = err_q;

endmodule

// File: rtl/brd_remap_ctl.sv
// Boot strap capture and per-master remap bits.
// The strap is sampled on every clock while reset is held and frozen afterwards.
// Only the first N_REMAP masters own a remap bit. A bit can be set by a write
// and is cleared only by reset. The other masters read a constant zero.
module brd_remap_ctl #(
    parameter int N_MASTERS = 4,
    parameter int N_REMAP   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 boot_sel_pin,
    input  logic                 remap_we,
    input  logic [N_REMAP-1:0]   remap_set,
    output logic                 boot_rom,
    output logic [N_MASTERS-1:0] remap_vec
);

    logic boot_q;

    // Follow the strap only while reset is asserted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_q <= boot_sel_pin;
        end
    end

    assign boot_rom = boot_q;

    genvar g;
    generate
        for (g = 0; g < N_MASTERS; g++) begin : g_master
            if (g < N_REMAP) begin : g_bit
                logic bit_q;
                // Set-only remap bit for this master
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        bit_q <= 1'b0;
                    end else if (remap_we && remap_set[g]) begin
                        bit_q <= 1'b1;
                    end
                end
                assign remap_vec[g] = bit_q;
            end else begin : g_none
                assign remap_vec[g] = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/brd_addr_decode.sv
// Combinational address decoder.
// Splits the address into a window index (upper bits) and a window offset.
// Window 0 goes to the boot target or, for a remapped master, to partition C.
// The SRAM windows are bounded by the current partition size. An access that
// misses every target gives an error with no select and a zero offset.
module brd_addr_decode
    import brd_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WIN_BITS  = 20,
    parameter int BANK_SH   = 14,
    parameter int CNT_W     = 4,
    parameter int N_MASTERS = 4,
    parameter int MID_W     = 2,
    parameter int WIN_A     = 1,
    parameter int WIN_B     = 2,
    parameter int WIN_C     = 3
) (
    input  logic [MID_W-1:0]     req_master,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [CNT_W-1:0]     a_banks,
    input  logic [CNT_W-1:0]     b_banks,
    input  logic [CNT_W-1:0]     c_banks,
    input  logic                 boot_rom,
    input  logic [N_MASTERS-1:0] remap_vec,
    output logic [N_TGT-1:0]     tgt_sel,
    output logic [ADDR_W-1:0]    tgt_offset,
    output logic                 tgt_err
);

    localparam int REG_W = ADDR_W - WIN_BITS;

    logic [REG_W-1:0]    region;
    logic [WIN_BITS-1:0] off;
    logic [WIN_BITS:0]   lim_a, lim_b, lim_c, lim;
    tgt_e                tgt_idx;
    logic                known, bounded, in_range;

    // Byte limit of a partition of the given bank count
    function automatic logic [WIN_BITS:0] bank_limit(input logic [CNT_W-1:0] n);
        return (WIN_BITS+1)'(n) << BANK_SH;
    endfunction

    // Split the address and size each SRAM window
    always_comb begin
        region = req_addr[ADDR_W-1:WIN_BITS];
        off    = req_addr[WIN_BITS-1:0];
        lim_a  = bank_limit(a_banks);
        lim_b  = bank_limit(b_banks);
        lim_c  = bank_limit(c_banks);
    end

    // Pick the candidate target and its bound from the window index
    always_comb begin
        tgt_idx = TGT_ROM;
        known   = 1'b1;
        bounded = 1'b0;
        lim     = '0;
        if (region == '0) begin
            if (remap_vec[req_master]) begin
                tgt_idx = TGT_PC;
                bounded = 1'b1;
                lim     = lim_c;
            end else if (boot_rom) begin
                tgt_idx = TGT_ROM;
            end else begin
                tgt_idx = TGT_CS0;
            end
        end else if (region == REG_W'(WIN_A)) begin
            tgt_idx = TGT_PA;
            bounded = 1'b1;
            lim     = lim_a;
        end else if (region == REG_W'(WIN_B)) begin
            tgt_idx = TGT_PB;
            bounded = 1'b1;
            lim     = lim_b;
        end else if (region == REG_W'(WIN_C)) begin
            tgt_idx = TGT_PC;
            bounded = 1'b1;
            lim     = lim_c;
        end else begin
            known = 1'b0;
        end
    end

    // Qualify the hit against the bound and form the response
    always_comb begin
        in_range = !bounded || ({1'b0, off} < lim);
        if (known && in_range) begin
            tgt_sel    = N_TGT'(1) << tgt_idx;
            tgt_offset = ADDR_W'(off);
            tgt_err    = 1'b0;
        end else begin
            tgt_sel    = '0;
            tgt_offset = '0;
            tgt_err    = 1'b1;
        end
    end

endmodule

// File: rtl/boot_remap_decoder.sv
// Top of the boot remap address decoder.
// Joins the partition size register, the strap and remap control, and the
// combinational decoder. Register writes act on the next cycle. The decode
// path from request to response has no register.
module boot_remap_decoder
    import brd_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int N_MASTERS   = 4,
    parameter int N_REMAP     = 2,
    parameter int N_BANKS     = 10,
    parameter int MIN_C_BANKS = 2,
    parameter int BANK_BYTES  = 16384,
    parameter int WIN_BITS    = 20,
    parameter int WIN_A       = 1,
    parameter int WIN_B       = 2,
    parameter int WIN_C       = 3,
    localparam int MID_W      = $clog2(N_MASTERS),
    localparam int CNT_W      = $clog2(N_BANKS + 1),
    localparam int BANK_SH    = $clog2(BANK_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 boot_sel_pin,
    input  logic                 cfg_we,
    input  logic [SZ_CODE_W-1:0] cfg_a_code,
    input  logic [SZ_CODE_W-1:0] cfg_b_code,
    input  logic                 remap_we,
    input  logic [N_REMAP-1:0]   remap_set,
    input  logic [MID_W-1:0]     req_master,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic [N_TGT-1:0]     tgt_sel,
    output logic [ADDR_W-1:0]    tgt_offset,
    output logic                 tgt_err,
    output logic                 cfg_err
);

    logic [CNT_W-1:0]     a_banks, b_banks, c_banks;
    logic                 boot_rom;
    logic [N_MASTERS-1:0] remap_vec;

    brd_part_cfg #(
        .N_BANKS     (N_BANKS),
        .MIN_C_BANKS (MIN_C_BANKS),
        .CNT_W       (CNT_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_a_code (cfg_a_code),
        .cfg_b_code (cfg_b_code),
        .a_banks    (a_banks),
        .b_banks    (b_banks),
        .c_banks    (c_banks),
        .cfg_err    (cfg_err)
    );

    brd_remap_ctl #(
        .N_MASTERS (N_MASTERS),
        .N_REMAP   (N_REMAP)
    ) u_remap (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_sel_pin (boot_sel_pin),
        .remap_we     (remap_we),
        .remap_set    (remap_set),
        .boot_rom     (boot_rom),
        .remap_vec    (remap_vec)
    );

    brd_addr_decode #(
        .ADDR_W    (ADDR_W),
        .WIN_BITS  (WIN_BITS),
        .BANK_SH   (BANK_SH),
        .CNT_W     (CNT_W),
        .N_MASTERS (N_MASTERS),
        .MID_W     (MID_W),
        .WIN_A     (WIN_A),
        .WIN_B     (WIN_B),
        .WIN_C     (WIN_C)
    ) u_dec (
        .req_master (req_master),
        .req_addr   (req_addr),
        .a_banks    (a_banks),
        .b_banks    (b_banks),
        .c_banks    (c_banks),
        .boot_rom   (boot_rom),
        .remap_vec  (remap_vec),
        .tgt_sel    (tgt_sel),
        .tgt_offset (tgt_offset),
        .tgt_err    (tgt_err)
    );

endmodule

// File: rtl/brd_chk.sv
// Property checker for the boot remap decoder, attached by bind.
// Watches the top-level ports together with the strap and remap state.
module brd_chk
    import brd_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int N_MASTERS = 4,
    parameter int N_REMAP   = 2,
    parameter int WIN_BITS  = 20,
    parameter int WIN_C     = 3,
    parameter int MID_W     = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_we,
    input logic [SZ_CODE_W-1:0] cfg_a_code,
    input logic [MID_W-1:0]     req_master,
    input logic [ADDR_W-1:0]    req_addr,
    input logic [N_TGT-1:0]     tgt_sel,
    input logic                 tgt_err,
    input logic                 cfg_err,
    input logic                 boot_rom,
    input logic [N_MASTERS-1:0] remap_vec
);

    localparam int REG_W = ADDR_W - WIN_BITS;
    logic [REG_W-1:0] region;
    assign region = req_addr[ADDR_W-1:WIN_BITS];

    // R10
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_sel));

    // R4
    err_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_err |-> (tgt_sel == '0));

    // R10
    high_window_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region > REG_W'(WIN_C)) |-> (tgt_err && tgt_sel == '0));

    // R5
    bad_code_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_a_code > 3'd3) |=> cfg_err);

    // R5
    cfg_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R8
    remap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((remap_vec & $past(remap_vec)) == $past(remap_vec)));

    // R2
    strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(boot_rom));

    // R7
    no_remap_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_master >= MID_W'(N_REMAP) && region == '0) |-> !tgt_sel[TGT_PC]);

endmodule

bind boot_remap_decoder brd_chk #(
    .ADDR_W    (ADDR_W),
    .N_MASTERS (N_MASTERS),
    .N_REMAP   (N_REMAP),
    .WIN_BITS  (WIN_BITS),
    .WIN_C     (WIN_C),
    .MID_W     (MID_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_a_code (cfg_a_code),
    .req_master (req_master),
    .req_addr   (req_addr),
    .tgt_sel    (tgt_sel),
    .tgt_err    (tgt_err),
    .cfg_err    (cfg_err),
    .boot_rom   (boot_rom),
    .remap_vec  (remap_vec)
);

// File: tb/sim_boot_remap_decoder.sv
`timescale 1ns/1ps
module sim_boot_remap_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_sel_pin = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_a_code = '0;
    logic [2:0]  cfg_b_code = '0;
    logic        remap_we = 1'b0;
    logic [1:0]  remap_set = '0;
    logic [1:0]  req_master = '0;
    logic [31:0] req_addr = '0;
    logic [4:0]  tgt_sel;
    logic [31:0] tgt_offset;
    logic        tgt_err;
    logic        cfg_err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // behavioural model state
    int m_a_kb, m_b_kb;
    bit m_cfgerr, m_boot;
    bit m_remap[2];

    always #5 clk = ~clk;

    boot_remap_decoder u0 (
        .clk(clk), .rst_n(rst_n), .boot_sel_pin(boot_sel_pin),
        .cfg_we(cfg_we), .cfg_a_code(cfg_a_code), .cfg_b_code(cfg_b_code),
        .remap_we(remap_we), .remap_set(remap_set),
        .req_master(req_master), .req_addr(req_addr),
        .tgt_sel(tgt_sel), .tgt_offset(tgt_offset), .tgt_err(tgt_err),
        .cfg_err(cfg_err)
    );

    function automatic int code_kb(input logic [2:0] c);
        case (c)
            3'd0: return 0;
            3'd1: return 16;
            3'd2: return 32;
            3'd3: return 64;
            default: return -1;
        endcase
    endfunction

    // model register updates at each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_a_kb = 0; m_b_kb = 0; m_cfgerr = 0;
            m_remap[0] = 0; m_remap[1] = 0;
            m_boot = boot_sel_pin;
        end else begin
            if (cfg_we) begin
                if (code_kb(cfg_a_code) >= 0 && code_kb(cfg_b_code) >= 0 &&
                    160 - code_kb(cfg_a_code) - code_kb(cfg_b_code) >= 32) begin
                    m_a_kb = code_kb(cfg_a_code);
                    m_b_kb = code_kb(cfg_b_code);
                end else begin
                    m_cfgerr = 1;
                end
            end
            if (remap_we) begin
                if (remap_set[0]) m_remap[0] = 1;
                if (remap_set[1]) m_remap[1] = 1;
            end
        end
    end

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h (master=%0d addr=%h)",
                     tag, what, act, exp, req_master, req_addr);
        end
    endtask

    task automatic compare(input string tag);
        int win, off, t, lim, c_kb;
        logic [4:0]  e_sel;
        logic [31:0] e_off;
        bit          e_err;
        win  = int'(req_addr >> 20);
        off  = int'(req_addr & 32'hFFFFF);
        c_kb = 160 - m_a_kb - m_b_kb;
        t = -1; lim = -1;
        if (win == 0) begin
            if (req_master < 2 && m_remap[req_master]) begin t = 4; lim = c_kb * 1024; end
            else t = m_boot ? 0 : 1;
        end else if (win == 1) begin t = 2; lim = m_a_kb * 1024; end
        else if (win == 2) begin t = 3; lim = m_b_kb * 1024; end
        else if (win == 3) begin t = 4; lim = c_kb * 1024; end
        if (t >= 0 && (lim < 0 || off < lim)) begin
            e_sel = 5'(1 << t); e_off = 32'(off); e_err = 0;
        end else begin
            e_sel = '0; e_off = '0; e_err = 1;
        end
        chk(tag, "tgt_sel", longint'(tgt_sel), longint'(e_sel));
        chk(tag, "tgt_offset", longint'(tgt_offset), longint'(e_off));
        chk(tag, "tgt_err", longint'(tgt_err), longint'(e_err));
        chk(tag, "cfg_err", longint'(cfg_err), longint'(m_cfgerr));
    endtask

    // one cycle: drive inputs, let the decode settle, compare against the model
    task automatic step(input string tag, input int m, input logic [31:0] a,
                        input bit cwe = 0, input logic [2:0] ac = 0, input logic [2:0] bc = 0,
                        input bit rwe = 0, input logic [1:0] rs = 0);
        @(negedge clk);
        req_master = 2'(m); req_addr = a;
        cfg_we = cwe; cfg_a_code = ac; cfg_b_code = bc;
        remap_we = rwe; remap_set = rs;
        #1;
        compare(tag);
    endtask

    task automatic do_reset(input bit pin);
        @(negedge clk);
        rst_n = 0; boot_sel_pin = pin;
        cfg_we = 0; remap_we = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        do_reset(1'b1);
        // R1: reset split
        step("R1", 0, 32'h0030_0000);
        step("R1", 2, 32'h0032_7FFC);
        step("R1", 1, 32'h0032_8000);
        step("R1", 0, 32'h0010_0000);
        step("R1", 3, 32'h0020_0010);
        // R2: strap captured at reset only
        step("R2", 0, 32'h0000_0100);
        boot_sel_pin = 1'b0;
        step("R2", 1, 32'h0000_0004);
        step("R2", 3, 32'h000F_FFFF);
        // R10: unmapped windows
        step("R10", 0, 32'h0040_0000);
        step("R10", 2, 32'hFFFF_FFFF);
        // R9: write and decode in one cycle sees old size, then R4 new sizes
        step("R9", 0, 32'h0010_0000, 1, 3'd1, 3'd3);
        step("R9", 0, 32'h0010_0000);
        step("R4", 1, 32'h0010_3FFF);
        step("R4", 1, 32'h0010_4000);
        step("R4", 2, 32'h0020_FFFF);
        step("R4", 2, 32'h0021_0000);
        step("R4", 3, 32'h0031_3FFF);
        step("R4", 3, 32'h0031_4000);
        // R5: illegal code rejected, flag sticky
        step("R5", 0, 32'h0010_3FFF, 1, 3'd5, 3'd0);
        step("R5", 0, 32'h0010_3FFF);
        step("R5", 0, 32'h0020_FFFF, 1, 3'd2, 3'd7);
        step("R5", 0, 32'h0020_FFFF, 1, 3'd2, 3'd2);
        step("R5", 0, 32'h0010_7FFF);
        step("R5", 0, 32'h0031_7FFF);
        // R6/R9: remap master 0, same-cycle access sees old mapping
        step("R9", 0, 32'h0000_0010, 0, 0, 0, 1, 2'b01);
        step("R6", 0, 32'h0000_0010);
        step("R6", 1, 32'h0000_0010);
        step("R6", 0, 32'h0001_7FFF);
        step("R6", 0, 32'h0001_8000);
        step("R6", 1, 32'h0000_0020, 0, 0, 0, 1, 2'b10);
        step("R6", 1, 32'h0000_0020);
        // R7: other masters ignore remap
        step("R7", 2, 32'h0000_0000);
        step("R7", 3, 32'h0000_0040);
        // R8: zero bits do not clear
        step("R8", 0, 32'h0000_0008, 0, 0, 0, 1, 2'b00);
        step("R8", 0, 32'h0000_0008);
        step("R8", 1, 32'h0000_0008);
        // R2/R8/R1: second reset with strap low clears remap and sizes
        do_reset(1'b0);
        step("R2", 0, 32'h0000_0000);
        step("R8", 1, 32'h0000_0044);
        step("R1", 2, 32'h0010_0000);
        step("R5", 2, 32'h0030_0000);
        boot_sel_pin = 1'b1;
        step("R2", 3, 32'h0000_0004);
        // R3: mixed traffic with occasional writes
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            bit cw, rw;
            a  = ((32'($urandom) % 5) << 20) | (32'($urandom) & 32'hFFFFF);
            cw = ($urandom % 10) == 0;
            rw = ($urandom % 25) == 0;
            step("R3", int'($urandom % 4), a, cw, 3'($urandom), 3'($urandom), rw, 2'($urandom));
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule